// File: doc/BRIEF.md
# Dual-Clock FIFO with Almost-Empty and Almost-Full Flags

This block is a 36-bit first-in first-out store that joins two unrelated clock domains. A wide producer port writes whole 36-bit long words on its own clock. A consumer port on a second clock reads the data back as whole long words, as 18-bit halves or as 9-bit quarters. Besides full and empty, each side has an active-low threshold flag. The read side warns when the store is nearly drained. The write side warns when it is nearly out of room. Each flag is registered on the clock of the side that acts on it.

The thresholds are parameters. The consumer bus size is taken from a two-bit input while reset is held. Pointers cross between the domains as Gray code through two synchronizing flops. A local transfer therefore moves the local flags on the same edge. A transfer from the other domain reaches them a few edges later. Occupancy is always counted in long words, so a narrow read that is part way through a long word leaves every flag alone.

Top module: `fifo_flag_core`

## Requirements
- R1: While rstN is low: almostEmptyN = 0, almostFullN = 0, emptyFlag = 1, fullFlag = 0 and rdData = 0. The rdSize code is captured on rdClk edges while reset is held.
- R2: A long word on wrData is stored on a wrClk edge only when wrCsN = 0, wrDir = 1, wrMbSel = 0 and wrEn = 1. Any other combination stores nothing.
- R3: A consumer transfer happens on an rdClk edge only when rdEn = 1 and rdMbSel = 0. In every other case rdData holds its value and the occupancy is unchanged.
- R4: On rdClk, almostEmptyN is 0 while occupancy is at most AE_OFS and 1 once occupancy reaches AE_OFS+1.
- R5: On wrClk, almostFullN is 0 while occupancy is at least DEPTH−AF_OFS and 1 once occupancy falls to DEPTH−AF_OFS−1.
- R6: fullFlag is 1 exactly when occupancy equals DEPTH. Writes while full are ignored.
- R7: emptyFlag is 1 exactly when occupancy is 0. Reads while empty are ignored and rdData holds.
- R8: The rdSize codes are 00 for a 36-bit long word, 01 for an 18-bit half and 10 for a 9-bit quarter. Lanes are read least-significant first. A half appears on rdData[17:0] and a quarter on rdData[8:0], with the upper bits 0. rdData is registered on the rdClk edge of the transfer.
- R9: In half or quarter mode, occupancy falls only on the transfer of the last lane of a long word. Earlier lanes change no flag.
- R10: A local write or read updates its own domain's flags on the edge of that transfer. A transfer in the other domain shows up within six edges of the flag's clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrClk | input | 1 | Producer clock |
| wrCsN | input | 1 | Producer select, active low |
| wrDir | input | 1 | Transfer direction, 1 = into the store |
| wrMbSel | input | 1 | Side-register select; must be 0 for the store |
| wrEn | input | 1 | Producer enable |
| wrData | input | 36 | Long word to store |
| almostFullN | output | 1 | Near-full warning, active low, wrClk domain |
| fullFlag | output | 1 | Store full, wrClk domain |
| rdClk | input | 1 | Consumer clock |
| rdEn | input | 1 | Consumer enable |
| rdMbSel | input | 1 | Side-register select; must be 0 for the store |
| rdSize | input | 2 | Consumer bus size code, captured during reset |
| rdData | output | 36 | Registered consumer data |
| almostEmptyN | output | 1 | Near-empty warning, active low, rdClk domain |
| emptyFlag | output | 1 | Store empty, rdClk domain |

## Verification
A wrong pointer or a stuck synchronizer makes a flag show the wrong occupancy. The bench sees this within six edges of that flag's clock, when it samples all four flags after each burst. A lane counter that advances the read pointer too early drops almostEmptyN or raises emptyFlag one lane ahead of time. It also sends the next long word to rdData at the very next narrow read. A wrong qualifier decode or a missing full or empty guard changes the stored sequence, which the bench finds on the first read-back that differs.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10
  } busSize_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic     wrStb;
    logic     rdStb;
    logic [1:0] rdLane;
    busSize_e size;
  } dpStrobe_t;

endpackage

// File: rtl/fifo_flag_ctrl.sv
module fifo_flag_ctrl
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int AE_OFS = 8,
  parameter int AF_OFS = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrReq,
  input  logic          rdReq,
  input  logic [1:0]    sizeIn,
  output dpStrobe_t     stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          almostFullN,
  output logic          fullFlag,
  output logic          almostEmptyN,
  output logic          emptyFlag
);

  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] AF_LVL   = PW'(DEPTH - AF_OFS);
  localparam logic [PW-1:0] AE_LVL   = PW'(AE_OFS);

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wPtr, wPtrNext, wGray, rSync1, rSync2, wCntNext;
  logic          wrStb;

  assign wrStb    = wrReq & ~fullFlag;
  assign wPtrNext = wPtr + PW'(wrStb);
  assign wCntNext = wPtrNext - gray2bin(rSync2);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wPtr        <= '0;
      wGray       <= '0;
      rSync1      <= '0;
      rSync2      <= '0;
      fullFlag    <= 1'b0;
      almostFullN <= 1'b0;
    end else begin
      wPtr        <= wPtrNext;
      wGray       <= bin2gray(wPtrNext);
      rSync1      <= rGray;
      rSync2      <= rSync1;
      fullFlag    <= (wCntNext == FULL_CNT);
      almostFullN <= (wCntNext < AF_LVL);
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rPtr, rPtrNext, rGray, wSync1, wSync2, rCntNext;
  logic [1:0]    laneQ;
  busSize_e      sizeQ;
  logic          lastLane, rdStb;

  // bus size taken only while reset is held
  always_ff @(posedge rdClk) begin
    if (!rstN) sizeQ <= busSize_e'(sizeIn);
  end

  always_comb begin
    case (sizeQ)
      SZ_WORD: lastLane = (laneQ == 2'd1);
      SZ_BYTE: lastLane = (laneQ == 2'd3);
      default: lastLane = 1'b1;
    endcase
  end

  assign rdStb    = rdReq & ~emptyFlag;
  assign rPtrNext = rPtr + PW'(rdStb & lastLane);
  assign rCntNext = gray2bin(wSync2) - rPtrNext;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rPtr         <= '0;
      rGray        <= '0;
      wSync1       <= '0;
      wSync2       <= '0;
      laneQ        <= '0;
      emptyFlag    <= 1'b1;
      almostEmptyN <= 1'b0;
    end else begin
      rPtr         <= rPtrNext;
      rGray        <= bin2gray(rPtrNext);
      wSync1       <= wGray;
      wSync2       <= wSync1;
      if (rdStb) laneQ <= lastLane ? 2'd0 : laneQ + 2'd1;
      emptyFlag    <= (rCntNext == '0);
      almostEmptyN <= (rCntNext > AE_LVL);
    end
  end

  assign stb.wrStb  = wrStb;
  assign stb.rdStb  = rdStb;
  assign stb.rdLane = laneQ;
  assign stb.size   = sizeQ;
  assign wrAddr     = wPtr[AW-1:0];
  assign rdAddr     = rPtr[AW-1:0];

endmodule

// File: rtl/fifo_flag_datapath.sv
module fifo_flag_datapath
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 36,
  localparam int AW   = $clog2(DEPTH),
  localparam int HALF = WIDTH / 2,
  localparam int QTR  = WIDTH / 4
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] headWord, laneData;
  logic [HALF-1:0]  wordLane [2];
  logic [QTR-1:0]   byteLane [4];

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) mem[wrAddr] <= wrData;
  end

  assign headWord = mem[rdAddr];

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_word
      assign wordLane[gi] = headWord[gi*HALF +: HALF];
    end
    for (gi = 0; gi < 4; gi++) begin : g_byte
      assign byteLane[gi] = headWord[gi*QTR +: QTR];
    end
  endgenerate

  always_comb begin
    laneData = '0;
    case (stb.size)
      SZ_WORD: laneData[HALF-1:0] = wordLane[stb.rdLane[0]];
      SZ_BYTE: laneData[QTR-1:0]  = byteLane[stb.rdLane];
      default: laneData           = headWord;
    endcase
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= laneData;
  end

endmodule

// File: rtl/fifo_flag_core.sv
module fifo_flag_core
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int WIDTH  = 36,
  parameter int AE_OFS = 8,
  parameter int AF_OFS = 8
) (
  input  logic             rstN,
  input  logic             wrClk,
  input  logic             wrCsN,
  input  logic             wrDir,
  input  logic             wrMbSel,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic             almostFullN,
  output logic             fullFlag,
  input  logic             rdClk,
  input  logic             rdEn,
  input  logic             rdMbSel,
  input  logic [1:0]       rdSize,
  output logic [WIDTH-1:0] rdData,
  output logic             almostEmptyN,
  output logic             emptyFlag
);

  localparam int AW = $clog2(DEPTH);

  dpStrobe_t     stb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic          wrReq, rdReq;

  assign wrReq = ~wrCsN & wrDir & ~wrMbSel & wrEn;
  assign rdReq = rdEn & ~rdMbSel;

  fifo_flag_ctrl #(
    .DEPTH(DEPTH), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)
  ) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrReq(wrReq), .rdReq(rdReq), .sizeIn(rdSize),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .almostFullN(almostFullN), .fullFlag(fullFlag),
    .almostEmptyN(almostEmptyN), .emptyFlag(emptyFlag)
  );

  fifo_flag_datapath #(
    .DEPTH(DEPTH), .WIDTH(WIDTH)
  ) u_dp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/fifo_flag_checker.sv
module fifo_flag_checker #(
  parameter int WIDTH = 36
) (
  input logic             rstN,
  input logic             wrClk,
  input logic             wrCsN,
  input logic             wrDir,
  input logic             wrMbSel,
  input logic             wrEn,
  input logic             almostFullN,
  input logic             fullFlag,
  input logic             rdClk,
  input logic             rdEn,
  input logic             rdMbSel,
  input logic [WIDTH-1:0] rdData,
  input logic             almostEmptyN,
  input logic             emptyFlag
);

  logic wrTake, rdTake;
  assign wrTake = ~wrCsN & wrDir & ~wrMbSel & wrEn & ~fullFlag;
  assign rdTake = rdEn & ~rdMbSel & ~emptyFlag;

  assert_full_in_af_R6: assert property (@(posedge wrClk) disable iff (!rstN)
    fullFlag |-> !almostFullN);

  assert_empty_in_ae_R7: assert property (@(posedge rdClk) disable iff (!rstN)
    emptyFlag |-> !almostEmptyN);

  assert_af_falls_on_write_R5: assert property (@(posedge wrClk) disable iff (!rstN)
    $fell(almostFullN) |-> $past(wrTake));

  assert_ae_falls_on_read_R4: assert property (@(posedge rdClk) disable iff (!rstN)
    $fell(almostEmptyN) |-> $past(rdTake));

  assert_data_hold_R3: assert property (@(posedge rdClk) disable iff (!rstN)
    !rdTake |=> $stable(rdData));

endmodule

bind fifo_flag_core fifo_flag_checker #(.WIDTH(WIDTH)) u_chk (
  .rstN(rstN), .wrClk(wrClk), .wrCsN(wrCsN), .wrDir(wrDir),
  .wrMbSel(wrMbSel), .wrEn(wrEn), .almostFullN(almostFullN),
  .fullFlag(fullFlag), .rdClk(rdClk), .rdEn(rdEn), .rdMbSel(rdMbSel),
  .rdData(rdData), .almostEmptyN(almostEmptyN), .emptyFlag(emptyFlag)
);

// File: tb/sim_fifo_flag_core.sv
module sim_fifo_flag_core;

  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD * 7 / 5;
  localparam int DEPTH  = 256;
  localparam int AE_OFS = 8;
  localparam int AF_OFS = 8;
  localparam logic [1:0] SZL = 2'b00, SZW = 2'b01, SZB = 2'b10;

  // op: 0 good write, 1 good read, 2 write with a bad qualifier, 3 read with rdMbSel=1
  localparam int VEC_N = 12;
  localparam int VEC [VEC_N][3] = '{
    '{0, 8, 8},   '{0, 1, 9},   '{1, 1, 8},   '{2, 4, 8},
    '{0, 239, 247}, '{3, 2, 247}, '{0, 1, 248}, '{1, 1, 247},
    '{0, 9, 256}, '{0, 3, 256}, '{1, 256, 0}, '{1, 2, 0}
  };

  logic rstN = 0, wrClk = 0, rdClk = 0;
  logic wrCsN = 1, wrDir = 0, wrMbSel = 0, wrEn = 0;
  logic [35:0] wrData = '0;
  logic rdEn = 0, rdMbSel = 0;
  logic [1:0] rdSize = SZL;
  logic almostFullN, fullFlag, almostEmptyN, emptyFlag;
  logic [35:0] rdData;

  int nVec = 0, nFail = 0, seq = 0, laneM = 0;
  logic [35:0] modelQ[$];
  logic [35:0] lastData = '0;
  logic [1:0]  curSize = SZL;

  always #(CLK_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2)  rdClk = ~rdClk;

  fifo_flag_core u0 (
    .rstN(rstN), .wrClk(wrClk), .wrCsN(wrCsN), .wrDir(wrDir),
    .wrMbSel(wrMbSel), .wrEn(wrEn), .wrData(wrData),
    .almostFullN(almostFullN), .fullFlag(fullFlag),
    .rdClk(rdClk), .rdEn(rdEn), .rdMbSel(rdMbSel), .rdSize(rdSize),
    .rdData(rdData), .almostEmptyN(almostEmptyN), .emptyFlag(emptyFlag)
  );

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] mkWord(input int k);
    logic [8:0] s = 9'(k);
    return {s ^ 9'h0a5, s + 9'd7, ~s, s};
  endfunction

  function automatic int lanesOf(input logic [1:0] sz);
    return (sz == SZW) ? 2 : (sz == SZB) ? 4 : 1;
  endfunction

  function automatic logic [35:0] laneOf(input logic [35:0] w, input logic [1:0] sz, input int ln);
    if (sz == SZW) return {18'b0, w[ln*18 +: 18]};
    if (sz == SZB) return {27'b0, w[ln*9 +: 9]};
    return w;
  endfunction

  task automatic settle();
    repeat (6) @(negedge wrClk);
    repeat (6) @(negedge rdClk);
  endtask

  task automatic chkFlags(input string tag, input int occ);
    chk({"R4 ", tag}, almostEmptyN, occ > AE_OFS);
    chk({"R5 ", tag}, almostFullN, occ < DEPTH - AF_OFS);
    chk({"R6 ", tag}, fullFlag, occ == DEPTH);
    chk({"R7 ", tag}, emptyFlag, occ == 0);
  endtask

  task automatic doReset(input logic [1:0] sz);
    rstN = 0; wrEn = 0; wrCsN = 1; rdEn = 0; rdSize = sz; curSize = sz;
    repeat (4) @(negedge rdClk);
    chk("R1 reset almostEmptyN", almostEmptyN, 0);
    chk("R1 reset almostFullN", almostFullN, 0);
    chk("R1 reset emptyFlag", emptyFlag, 1);
    chk("R1 reset fullFlag", fullFlag, 0);
    chk("R1 reset rdData", rdData, 0);
    rstN = 1;
    rdSize = ~sz;  // later changes must not matter
    modelQ.delete(); laneM = 0; lastData = '0;
    settle();
  endtask

  task automatic writeBeats(input int n, input int mode, input bit immed);
    for (int i = 0; i < n; i++) begin
      bit ok;
      @(negedge wrClk);
      wrCsN   = (mode == 2) && (i % 4 == 0);
      wrDir   = !((mode == 2) && (i % 4 == 1));
      wrMbSel = (mode == 2) && (i % 4 == 2);
      wrEn    = !((mode == 2) && (i % 4 == 3));
      wrData  = mkWord(seq); seq++;
      ok = (mode == 0) && (modelQ.size() < DEPTH);
      if (ok) modelQ.push_back(wrData);
    end
    @(negedge wrClk);
    wrEn = 0; wrCsN = 1;
    if (immed) begin
      chk("R10 local almostFullN", almostFullN, modelQ.size() < DEPTH - AF_OFS);
      chk("R10 local fullFlag", fullFlag, modelQ.size() == DEPTH);
    end
  endtask

  task automatic readBeats(input int n, input bit mb, input bit immed);
    for (int i = 0; i < n; i++) begin
      bit ok;
      @(negedge rdClk);
      rdEn = 1; rdMbSel = mb;
      ok = !mb && (modelQ.size() > 0);
      if (ok) begin
        lastData = laneOf(modelQ[0], curSize, laneM);
        if (laneM == lanesOf(curSize) - 1) begin
          void'(modelQ.pop_front());
          laneM = 0;
        end else laneM++;
      end
      @(negedge rdClk);
      rdEn = 0; rdMbSel = 0;
      chk(ok ? "R8 read data" : "R3 R7 ignored read holds data", rdData, lastData);
    end
    if (immed) chk("R10 local almostEmptyN", almostEmptyN, modelQ.size() > AE_OFS);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    doReset(SZL);
    chkFlags("after reset", 0);

    // table walk, long-word mode (R2 R3 R4 R5 R6 R7)
    for (int v = 0; v < VEC_N; v++) begin
      case (VEC[v][0])
        0: writeBeats(VEC[v][1], 0, 0);
        1: readBeats(VEC[v][1], 0, 0);
        2: writeBeats(VEC[v][1], 2, 0);
        default: readBeats(VEC[v][1], 1, 0);
      endcase
      settle();
      chkFlags($sformatf("vector %0d", v), VEC[v][2]);
    end

    // R10: own-domain flag moves on the edge of the write
    doReset(SZL);
    writeBeats(247, 0, 0);
    settle();
    writeBeats(1, 0, 1);
    writeBeats(8, 0, 1);
    readBeats(1, 0, 0);
    settle();
    chkFlags("R10 remote read seen by write side", 255);

    // R9 R8: half-word mode
    doReset(SZW);
    writeBeats(9, 0, 0);
    settle();
    chkFlags("R9 word mode filled", 9);
    readBeats(1, 0, 0);
    settle();
    chkFlags("R9 after first half", 9);
    readBeats(1, 0, 1);
    readBeats(16, 0, 0);
    settle();
    chkFlags("R9 word mode drained", 0);

    // R9 R8: quarter mode
    doReset(SZB);
    writeBeats(9, 0, 0);
    settle();
    readBeats(3, 0, 0);
    settle();
    chkFlags("R9 after three quarters", 9);
    readBeats(1, 0, 1);
    readBeats(32, 0, 0);
    settle();
    chkFlags("R9 byte mode drained", 0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule